// File: doc/BRIEF.md
# Phase-Error Lock Detector with Hysteresis

This block watches the reference and feedback pulses of a phase-locked loop and decides whether the loop is locked. It runs on a fast sampling clock. In every phase-detector cycle it measures how many sample clocks separate the reference rising edge from the feedback rising edge. The measurement is the same whichever edge comes first. If one edge waits too long for its partner, that cycle counts as a large error.

The lock flag is set only after a run of consecutive small-error cycles. A precision input selects a run of three or five. Once set, the flag is cleared only by a cycle whose error exceeds a second, wider threshold, which gives the flag hysteresis. The two thresholds correspond to 15 ns and 25 ns and are turned into sample counts from the sample period by parameters.

A power-down input clears the detector. An output-enable signal can be made to wait for lock, so that a downstream RF stage stays muted until the loop has settled.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is active, and right after it, `lock` is 0. With `mute_en`=1 the output `out_en` is then also 0.
- R2: With `prec_sel`=0, `lock` rises after three consecutive measured cycles whose error is below ENTRY counts (15 with default parameters). It is high from the second clock edge after the closing edge of the third such cycle.
- R3: With `prec_sel`=1, five consecutive cycles below ENTRY counts are needed, and four are not enough.
- R4: Once locked, a cycle with an error of at most EXIT counts (25 by default) leaves `lock` high, even when the error is ENTRY or more. A single cycle with an error above EXIT clears `lock` on the second edge after its closing edge.
- R5: While unlocked, any cycle with an error of ENTRY counts or more restarts the consecutive-good run from zero.
- R6: The error is the absolute edge distance in sample clocks. A cycle where the feedback edge leads gives the same error as one where the reference edge leads by the same amount.
- R7: If a first edge gets no partner edge within TIMEOUT sample clocks (40 by default, larger than EXIT), the cycle is closed with error TIMEOUT. It therefore counts as a large error.
- R8: A clock edge that sees `pwr_dn`=1 clears `lock`, the run count and any measurement in progress. This holds even when a lock-completing measurement lands in the same edge. After release, a full new run is required.
- R9: `out_en` is 0 whenever `pwr_dn`=1. Otherwise `out_en` is 1 when `mute_en`=0, and equals `lock` when `mute_en`=1.
- R10: Reference and feedback edges seen on the same sample edge give an error of 0, which counts as good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down, synchronous clear of the detector |
| ref_pulse | input | 1 | Reference pulse from the divided reference |
| fb_pulse | input | 1 | Feedback pulse from the divided oscillator |
| prec_sel | input | 1 | Run length select: 0 gives three good cycles, 1 gives five |
| mute_en | input | 1 | 1 keeps out_en off until lock |
| lock | output | 1 | Active-high lock flag |
| out_en | output | 1 | Output-stage enable |

## Verification
Power-down and lock completion can fall on the same clock edge. The bench times a power-down pulse to the edge where the third good measurement would set the flag. It then expects `lock` to stay low, and expects two more good cycles after release to still leave it low. A behavioural model keeps edge time stamps as integers and is compared with `lock` and `out_en` on every clock, in addition to the fixed checkpoints after each phase-detector cycle. The stimulus also places errors right at the boundaries: 14/15 counts for entry, and 25/26 counts for exit.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_REF_LEAD = 2'd1,
    MS_FB_LEAD  = 2'd2
  } meas_state_e;

  // Converts a time in picoseconds to whole sample-clock counts.
  function automatic int unsigned ps_to_counts(input int unsigned t_ps,
                                               input int unsigned sample_ps);
    return t_ps / sample_ps;
  endfunction

  // Number of consecutive good cycles needed for lock entry.
  function automatic int unsigned run_needed(input logic prec,
                                             input int unsigned short_run,
                                             input int unsigned long_run);
    return prec ? long_run : short_run;
  endfunction

endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pulse_i;
  end

  assign rise_o = pulse_i & ~prev_q;
endmodule

// File: rtl/lockdet_meter.sv
module lockdet_meter #(
  parameter int unsigned TIMEOUT_CNT = 40,
  parameter int unsigned ERR_W       = $clog2(TIMEOUT_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             meas_valid,
  output logic [ERR_W-1:0] meas_err
);
  import lockdet_pkg::*;

  localparam logic [ERR_W-1:0] TMO_L = ERR_W'(TIMEOUT_CNT);

  meas_state_e      state_q;
  logic [ERR_W-1:0] cnt_q;

  // Named internal events.
  logic partner_rise;
  logic timeout_hit;
  logic both_rise;

  assign both_rise    = ref_rise & fb_rise;
  assign partner_rise = (state_q == MS_REF_LEAD) ? fb_rise :
                        (state_q == MS_FB_LEAD)  ? ref_rise : 1'b0;
  assign timeout_hit  = (state_q != MS_IDLE) && !partner_rise && (cnt_q == TMO_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MS_IDLE;
      cnt_q      <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
    end else if (pwr_dn) begin
      state_q    <= MS_IDLE;
      cnt_q      <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
    end else begin
      meas_valid <= 1'b0;
      case (state_q)
        MS_IDLE: begin
          if (both_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= '0;
          end else if (ref_rise) begin
            state_q <= MS_REF_LEAD;
            cnt_q   <= ERR_W'(1);
          end else if (fb_rise) begin
            state_q <= MS_FB_LEAD;
            cnt_q   <= ERR_W'(1);
          end
        end
        default: begin
          if (partner_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= cnt_q;
            state_q    <= MS_IDLE;
          end else if (timeout_hit) begin
            meas_valid <= 1'b1;
            meas_err   <= TMO_L;
            state_q    <= MS_IDLE;
          end else begin
            cnt_q <= cnt_q + ERR_W'(1);
          end
        end
      endcase
    end
  end

  AST_ERR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (meas_err <= TMO_L)) else $error("meas_err above timeout"); // R7
  AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != MS_IDLE) |-> (cnt_q != '0 && cnt_q <= TMO_L)) else $error("wait count out of range"); // R7
  AST_TIMEOUT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_hit && !pwr_dn) |=> (meas_valid && meas_err == TMO_L)) else $error("timeout did not close cycle"); // R7
  AST_SAME_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_IDLE && both_rise && !pwr_dn) |=> (meas_valid && meas_err == '0)) else $error("coincident edges not zero"); // R10
endmodule

// File: rtl/lockdet_hyst.sv
module lockdet_hyst #(
  parameter int unsigned ENTRY_CNT = 15,
  parameter int unsigned EXIT_CNT  = 25,
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5,
  parameter int unsigned ERR_W     = 6,
  parameter int unsigned RUN_W     = $clog2(LONG_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             prec_sel,
  input  logic             meas_valid,
  input  logic [ERR_W-1:0] meas_err,
  output logic             lock_o
);
  import lockdet_pkg::*;

  localparam logic [ERR_W-1:0] ENTRY_L = ERR_W'(ENTRY_CNT);
  localparam logic [ERR_W-1:0] EXIT_L  = ERR_W'(EXIT_CNT);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;
  logic [RUN_W-1:0] need;

  // Named internal events.
  logic meas_good;
  logic meas_exit;
  logic run_done;

  assign need      = RUN_W'(run_needed(prec_sel, SHORT_RUN, LONG_RUN));
  assign meas_good = meas_valid && (meas_err < ENTRY_L);
  assign meas_exit = meas_valid && (meas_err > EXIT_L);
  assign run_inc   = run_q + RUN_W'(1);
  assign run_done  = meas_good && (run_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o <= 1'b0;
      run_q  <= '0;
    end else if (pwr_dn) begin
      lock_o <= 1'b0;
      run_q  <= '0;
    end else if (!lock_o) begin
      if (meas_valid) begin
        if (run_done) begin
          lock_o <= 1'b1;
          run_q  <= '0;
        end else if (meas_good) begin
          run_q <= run_inc;
        end else begin
          run_q <= '0;
        end
      end
    end else if (meas_exit) begin
      lock_o <= 1'b0;
      run_q  <= '0;
    end
  end

  AST_ENTRY_EARNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(meas_good)) else $error("lock rose without good cycle"); // R2
  AST_RUN_BELOW_NEED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_W'(LONG_RUN)) else $error("run count overflow"); // R3
  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(pwr_dn) || $past(meas_exit))) else $error("lock fell without cause"); // R4
  AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && meas_valid && !meas_good) |=> (run_q == '0 && !lock_o)) else $error("bad cycle kept run"); // R5
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!lock_o && run_q == '0)) else $error("power-down did not clear"); // R8
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int unsigned SAMPLE_PS   = 1000,
  parameter int unsigned ENTRY_PS    = 15000,
  parameter int unsigned EXIT_PS     = 25000,
  parameter int unsigned TIMEOUT_CNT = 40,
  parameter int unsigned SHORT_RUN   = 3,
  parameter int unsigned LONG_RUN    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic prec_sel,
  input  logic mute_en,
  output logic lock,
  output logic out_en
);
  import lockdet_pkg::*;

  localparam int unsigned ENTRY_CNT = ps_to_counts(ENTRY_PS, SAMPLE_PS);
  localparam int unsigned EXIT_CNT  = ps_to_counts(EXIT_PS, SAMPLE_PS);
  localparam int unsigned ERR_W     = $clog2(TIMEOUT_CNT + 1);
  localparam int unsigned N_CH      = 2;

  logic [N_CH-1:0] pulse_vec;
  logic [N_CH-1:0] rise_vec;
  logic            ref_rise;
  logic            fb_rise;
  logic            meas_valid;
  logic [ERR_W-1:0] meas_err;

  assign pulse_vec = {fb_pulse, ref_pulse};

  for (genvar g = 0; g < N_CH; g++) begin : g_edge
    lockdet_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (pulse_vec[g]),
      .rise_o  (rise_vec[g])
    );
  end

  assign ref_rise = rise_vec[0];
  assign fb_rise  = rise_vec[1];

  lockdet_meter #(
    .TIMEOUT_CNT (TIMEOUT_CNT),
    .ERR_W       (ERR_W)
  ) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .ref_rise   (ref_rise),
    .fb_rise    (fb_rise),
    .meas_valid (meas_valid),
    .meas_err   (meas_err)
  );

  lockdet_hyst #(
    .ENTRY_CNT (ENTRY_CNT),
    .EXIT_CNT  (EXIT_CNT),
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN),
    .ERR_W     (ERR_W)
  ) u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .prec_sel   (prec_sel),
    .meas_valid (meas_valid),
    .meas_err   (meas_err),
    .lock_o     (lock)
  );

  assign out_en = !pwr_dn && (!mute_en || lock);

  AST_MUTED_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && out_en) |-> ($past(meas_valid) || $past(lock))) else $error("unmuted without lock history"); // R9
endmodule

// File: tb/sim_pll_lock_detect.sv
module sim_pll_lock_detect;
  localparam int SAMPLE_PS = 1000;
  localparam int ENTRY_N   = 15000 / SAMPLE_PS;
  localparam int EXIT_N    = 25000 / SAMPLE_PS;
  localparam int TMO       = 40;

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, prec_sel = 1'b0, mute_en = 1'b1;
  wire  lock, out_en;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  pll_lock_detect #(.SAMPLE_PS(SAMPLE_PS), .TIMEOUT_CNT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .prec_sel(prec_sel), .mute_en(mute_en),
    .lock(lock), .out_en(out_en));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: time stamps and integer arithmetic.
  int  k = 0, m_lock = 0, m_run = 0, m_side = 0, m_start = 0;
  int  m_pv = 0, m_pe = 0;
  bit  rp = 0, fp = 0;

  initial forever begin
    @(posedge clk);
    k++;
    if (!rst_n) begin
      m_lock = 0; m_run = 0; m_side = 0; m_pv = 0; rp = 0; fp = 0;
    end else begin
      bit re, fe; int need, nv, ne;
      re = ref_pulse && !rp; fe = fb_pulse && !fp;
      rp = ref_pulse; fp = fb_pulse;
      need = prec_sel ? 5 : 3;
      if (m_pv) begin
        if (m_lock == 0) begin
          if (m_pe < ENTRY_N) begin
            m_run++;
            if (m_run >= need) begin m_lock = 1; m_run = 0; end
          end else m_run = 0;
        end else if (m_pe > EXIT_N) begin
          m_lock = 0; m_run = 0;
        end
      end
      nv = 0; ne = 0;
      if (m_side == 0) begin
        if (re && fe) begin nv = 1; ne = 0; end
        else if (re) begin m_side = 1; m_start = k; end
        else if (fe) begin m_side = 2; m_start = k; end
      end else if ((m_side == 1 && fe) || (m_side == 2 && re)) begin
        nv = 1; ne = k - m_start; m_side = 0;
      end else if (k - m_start == TMO) begin
        nv = 1; ne = TMO; m_side = 0;
      end
      m_pv = nv; m_pe = ne;
      if (pwr_dn) begin m_lock = 0; m_run = 0; m_side = 0; m_pv = 0; end
    end
    #5;
    if (rst_n && !done) begin
      chk({cur_req, " model lock"}, lock, m_lock[0]);
      chk({cur_req, " model out_en"}, out_en, !pwr_dn && (!mute_en || m_lock != 0));
    end
  end

  // One phase-detector cycle: edges at given offsets (-1 = absent).
  task automatic cyc(input int dref, input int dfb, input int pdi = -1, input int len = 60);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ref_pulse = (dref >= 0 && i >= dref && i < dref + 2);
      fb_pulse  = (dfb >= 0 && i >= dfb && i < dfb + 2);
      pwr_dn    = (i == pdi);
    end
  endtask

  task automatic summary;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", lock, 1'b0);
    chk("R1 out_en in reset", out_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock after reset", lock, 1'b0);

    cur_req = "R2";
    cyc(5, 10); cyc(5, 10);
    chk("R2 two goods", lock, 1'b0);
    cyc(5, 10);
    chk("R2 three goods", lock, 1'b1);
    chk("R9 muted out_en follows lock", out_en, 1'b1);

    cur_req = "R4";
    cyc(5, 25); chk("R4 err 20 keeps lock", lock, 1'b1);
    cyc(5, 30); chk("R4 err 25 keeps lock", lock, 1'b1);
    cyc(5, 31); chk("R4 err 26 exits", lock, 1'b0);
    chk("R9 muted out_en off", out_en, 1'b0);

    cur_req = "R5";
    cyc(5, 10); cyc(5, 10); cyc(5, 20);
    chk("R5 err 15 blocks", lock, 1'b0);
    cyc(5, 10); cyc(5, 10);
    chk("R5 run restarted", lock, 1'b0);
    cyc(5, 10);
    chk("R5 new run locks", lock, 1'b1);

    cur_req = "R6";
    cyc(5, 36); chk("R6 ref-lead 31 exits", lock, 1'b0);
    cyc(19, 5); cyc(19, 5); cyc(19, 5);
    chk("R6 fb-lead 14 counts good", lock, 1'b1);
    cyc(40, 5); chk("R6 fb-lead 35 exits", lock, 1'b0);

    cur_req = "R10";
    cyc(8, 8); cyc(8, 8); cyc(8, 8);
    chk("R10 coincident edges lock", lock, 1'b1);

    cur_req = "R7";
    cyc(5, -1); chk("R7 lone ref times out", lock, 1'b0);
    cyc(10, 5); cyc(10, 5); cyc(-1, 5);
    chk("R7 lone fb blocks run", lock, 1'b0);

    cur_req = "R3";
    prec_sel = 1'b1;
    cyc(5, 10); cyc(5, 10); cyc(5, 10); cyc(5, 10);
    chk("R3 four goods not enough", lock, 1'b0);
    cyc(5, 10);
    chk("R3 five goods lock", lock, 1'b1);
    prec_sel = 1'b0;

    cur_req = "R8";
    cyc(5, -1);
    cyc(5, 10); cyc(5, 10); cyc(5, 10, 11);
    chk("R8 power-down beats lock entry", lock, 1'b0);
    cyc(5, 10); cyc(5, 10);
    chk("R8 run cleared by power-down", lock, 1'b0);
    cyc(5, 10);
    chk("R8 relock after full run", lock, 1'b1);
    @(negedge clk); pwr_dn = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 held power-down lock", lock, 1'b0);
    chk("R9 power-down out_en", out_en, 1'b0);
    pwr_dn = 1'b0;
    @(negedge clk);
    chk("R8 stays unlocked after release", lock, 1'b0);

    cur_req = "R9";
    mute_en = 1'b0;
    @(negedge clk);
    chk("R9 unmuted out_en while unlocked", out_en, 1'b1);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk("R9 unmuted out_en in power-down", out_en, 1'b0);
    pwr_dn = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule